// File: doc/BRIEF.md
# Page-Miss Wait-State Generator

This block produces the two ready indications that a processor bus needs while an access is in flight. The first, data ready, drops for a single clock whenever an access lands on a page other than the one used by the access before it. This gives the memory system one extra cycle to open the new page. The second, address ready, holds the processor off for a programmable number of wait states after each address strobe. That number runs from zero to three and comes out of reset at three.

An access starts at the first rising clock edge that samples the address strobe high after it was low. On that edge the block compares the supplied page number against a stored current page and loads the wait counter. Both ready outputs are registered, so their response appears in the cycle after that edge. A small write port sets the wait count. A new value affects accesses that start at later edges and leaves any access already in progress unchanged.

Top module: `pmw_ready_gen`

## Requirements
- R1: Out of reset both `dat_rdy` and `adr_rdy` are 1 (no wait requested), and both stay 1 until an access starts.
- R2: An access starts at a rising clock edge where `strb` is sampled 1 and was sampled 0 at the previous edge. `dat_rdy` can go low only in the cycle right after such an edge.
- R3: The first access after reset always counts as a page miss, whatever its page number.
- R4: On a page miss, `dat_rdy` is 0 for exactly one clock: the cycle after the start edge.
- R5: An access whose page equals the stored current page keeps `dat_rdy` at 1.
- R6: The stored current page takes the page of every access. Pages A, B, A in sequence therefore give three misses, and A, A gives one.
- R7: With a wait count of N, `adr_rdy` is 0 for the N cycles that follow the start edge while `strb` stays 1, and is 1 from then on until the strobe ends.
- R8: With a wait count of 0, `adr_rdy` stays 1 for the whole strobe.
- R9: When `strb` is sampled 0, `adr_rdy` is 1 in the following cycle, which cuts short any remaining wait.
- R10: When `cfg_we` is 1 at an edge, `cfg_wait` becomes the wait count for accesses that start at later edges. The access that starts at that same edge, or one already waiting, keeps its old count.
- R11: After reset the wait count is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| strb | input | 1 | Address strobe, active high |
| page | input | PAGE_W | Page number of the current access |
| cfg_we | input | 1 | Write enable for the wait-count register |
| cfg_wait | input | WAIT_W | New wait count |
| dat_rdy | output | 1 | Data ready, 0 for one clock on a page miss |
| adr_rdy | output | 1 | Address ready, 0 during programmed wait states |

## Verification
The bench targets the first access after reset. A design that trusted the reset value of the page register would let that access through with no wait. It runs the sequence A, B, A: a design that updated the page only on hits, or never, would miss the final A or flag a false hit. It also drops the strobe in the middle of a wait and writes the count on the same edge that starts an access. A design that kept counting after the strobe ended would hold address ready low into idle time. A design that let the new count bypass the register would change the length of the access already under way.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
   // Largest count a field of the given width can hold.
   function automatic int unsigned field_max(input int unsigned w);
      return (1 << w) - 1;
   endfunction

   typedef enum logic {
      RDY_HOLD = 1'b0,
      RDY_GO   = 1'b1
   } rdy_e;
endpackage

// File: rtl/pmw_cfg_reg.sv
module pmw_cfg_reg #(
   parameter int unsigned WAIT_W   = 2,
   parameter int unsigned WAIT_RST = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WAIT_W-1:0] wdata,
   output logic [WAIT_W-1:0] wait_cnt
);
   localparam logic [WAIT_W-1:0] RST_VAL = WAIT_W'(WAIT_RST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  wait_cnt <= RST_VAL;
      else if (we) wait_cnt <= wdata;
   end
endmodule

// File: rtl/pmw_page_track.sv
module pmw_page_track #(
   parameter int unsigned PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PAGE_W-1:0] page,
   output logic              rdy
);
   import pmw_pkg::*;

   logic [PAGE_W-1:0] cur_page;
   logic              cur_valid;
   logic              miss;

   // A miss needs a live access and either no stored page or a different one.
   assign miss = start && (!cur_valid || (page != cur_page));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_page  <= '0;
         cur_valid <= 1'b0;
         rdy       <= RDY_GO;
      end else begin
         rdy <= miss ? RDY_HOLD : RDY_GO;
         if (start) begin
            cur_page  <= page;
            cur_valid <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pmw_wait_ctr.sv
module pmw_wait_ctr #(
   parameter int unsigned WAIT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strb,
   input  logic              start,
   input  logic [WAIT_W-1:0] load,
   output logic              rdy
);
   import pmw_pkg::*;

   logic [WAIT_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                left <= '0;
      else if (!strb)            left <= '0;
      else if (start)            left <= load;
      else if (left != '0)       left <= left - 1'b1;
   end

   assign rdy = (left == '0) ? RDY_GO : RDY_HOLD;
endmodule

// File: rtl/pmw_ready_gen.sv
module pmw_ready_gen #(
   parameter int unsigned PAGE_W   = 8,
   parameter int unsigned WAIT_W   = 2,
   parameter int unsigned WAIT_RST = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strb,
   input  logic [PAGE_W-1:0] page,
   input  logic              cfg_we,
   input  logic [WAIT_W-1:0] cfg_wait,
   output logic              dat_rdy,
   output logic              adr_rdy
);
   import pmw_pkg::*;

   localparam int unsigned WMAX = field_max(WAIT_W);

   generate
      if (PAGE_W < 1) begin : g_bad_page
         $error("pmw_ready_gen: PAGE_W must be at least 1");
      end
      if (WAIT_W < 1 || WAIT_W > 8) begin : g_bad_wait_w
         $error("pmw_ready_gen: WAIT_W must lie in 1..8");
      end
      if (WAIT_RST > WMAX) begin : g_bad_wait_rst
         $error("pmw_ready_gen: WAIT_RST does not fit in WAIT_W bits");
      end
   endgenerate

   logic              strb_q;
   logic              start;
   logic [WAIT_W-1:0] wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strb_q <= 1'b0;
      else        strb_q <= strb;
   end

   assign start = strb && !strb_q;

   pmw_cfg_reg #(.WAIT_W(WAIT_W), .WAIT_RST(WAIT_RST)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .wdata    (cfg_wait),
      .wait_cnt (wait_cnt)
   );

   pmw_page_track #(.PAGE_W(PAGE_W)) u_page (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .page  (page),
      .rdy   (dat_rdy)
   );

   pmw_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .strb  (strb),
      .start (start),
      .load  (wait_cnt),
      .rdy   (adr_rdy)
   );
endmodule

// File: rtl/pmw_ready_gen_chk.sv
module pmw_ready_gen_chk #(
   parameter int unsigned WAIT_W   = 2,
   parameter int unsigned WAIT_RST = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strb,
   input logic              cfg_we,
   input logic [WAIT_W-1:0] cfg_wait,
   input logic              dat_rdy,
   input logic              adr_rdy
);
   localparam int unsigned WMAX = (1 << WAIT_W) - 1;

   logic              c_sq;
   logic              c_start_d;
   logic              c_zero_d;
   logic [WAIT_W-1:0] c_cfg;
   logic [WAIT_W:0]   c_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_sq      <= 1'b0;
         c_start_d <= 1'b0;
         c_zero_d  <= 1'b0;
         c_cfg     <= WAIT_W'(WAIT_RST);
         c_run     <= '0;
      end else begin
         c_sq      <= strb;
         c_start_d <= strb && !c_sq;
         c_zero_d  <= strb && !c_sq && (c_cfg == '0);
         if (cfg_we) c_cfg <= cfg_wait;
         if (adr_rdy)                    c_run <= '0;
         else if (c_run != (WAIT_W+1)'(WMAX + 1)) c_run <= c_run + 1'b1;
      end
   end

   AST_DRDY_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) !dat_rdy |=> dat_rdy);                      // R4
   AST_DRDY_CAUSE:    assert property (@(posedge clk) disable iff (!rst_n) !dat_rdy |-> c_start_d);                    // R2
   AST_ARDY_FALL:     assert property (@(posedge clk) disable iff (!rst_n) $fell(adr_rdy) |-> c_start_d);              // R7
   AST_ARDY_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) !adr_rdy |-> (c_run < (WAIT_W+1)'(WMAX))); // R7
   AST_ARDY_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) !strb |=> adr_rdy);                         // R9
   AST_ZERO_WAIT:     assert property (@(posedge clk) disable iff (!rst_n) c_zero_d |-> adr_rdy);                      // R8
endmodule

bind pmw_ready_gen pmw_ready_gen_chk #(.WAIT_W(WAIT_W), .WAIT_RST(WAIT_RST)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .strb     (strb),
   .cfg_we   (cfg_we),
   .cfg_wait (cfg_wait),
   .dat_rdy  (dat_rdy),
   .adr_rdy  (adr_rdy)
);

// File: tb/pmw_ready_gen_tb.sv
module pmw_ready_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strb = 1'b0;
   logic [PW-1:0] page = '0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_wait = '0;
   logic          dat_rdy;
   logic          adr_rdy;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Reference state derived from the requirements.
   bit          m_sq = 1'b0;
   bit          m_valid = 1'b0;
   bit [PW-1:0] m_page = '0;
   int          m_wait = 3;      // R11: count after reset
   int          m_left = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmw_ready_gen #(.PAGE_W(PW), .WAIT_W(2), .WAIT_RST(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .strb(strb), .page(page),
      .cfg_we(cfg_we), .cfg_wait(cfg_wait),
      .dat_rdy(dat_rdy), .adr_rdy(adr_rdy)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   // One clock: drive at falling edge, advance the model at the rising edge, compare after it.
   task automatic cyc(input bit s, input bit [PW-1:0] p, input bit we, input bit [1:0] w, input string req);
      bit start, exp_d;
      string dtag, atag;
      @(negedge clk);
      strb = s; page = p; cfg_we = we; cfg_wait = w;
      @(posedge clk);
      #1;
      start = s && !m_sq;
      exp_d = !(start && (!m_valid || p != m_page));
      dtag  = start ? (exp_d ? "R5" : "R4") : "R2";
      if (start) begin m_valid = 1'b1; m_page = p; end
      if (!s)          m_left = 0;
      else if (start)  m_left = m_wait;
      else if (m_left != 0) m_left--;
      atag = !s ? "R9" : (m_wait == 0 ? "R8" : "R7");
      if (we) m_wait = w;
      m_sq = s;
      check({dtag, " ", req}, "dat_rdy", dat_rdy, exp_d);
      check({atag, " ", req}, "adr_rdy", adr_rdy, m_left == 0);
   endtask

   task automatic access(input bit [PW-1:0] p, input int len, input string req);
      for (int i = 0; i < len; i++) cyc(1'b1, p, 1'b0, 2'd0, req);
      cyc(1'b0, p, 1'b0, 2'd0, req);
   endtask

   task automatic set_wait(input bit [1:0] w);
      cyc(1'b0, '0, 1'b1, w, "R10");
   endtask

   initial begin
      void'($urandom(7));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check("R1", "dat_rdy after reset", dat_rdy, 1'b1);
      check("R1", "adr_rdy after reset", adr_rdy, 1'b1);
      cyc(1'b0, '0, 1'b0, 2'd0, "R1");

      access(8'h00, 6, "R3 R11");      // first access misses even at page 0, 3 waits
      access(8'h00, 2, "R5");
      access(8'h11, 2, "R6");
      access(8'h22, 2, "R6");
      access(8'h11, 2, "R6");
      access(8'h11, 2, "R6");
      set_wait(2'd0);
      access(8'h30, 4, "R8");
      set_wait(2'd2);
      access(8'h30, 5, "R7");
      set_wait(2'd3);
      access(8'h31, 1, "R9");          // strobe drops during the wait
      access(8'h31, 2, "R9");
      // write on the same edge as a start: old count 3 applies now
      cyc(1'b1, 8'h40, 1'b1, 2'd1, "R10");
      cyc(1'b1, 8'h40, 1'b1, 2'd0, "R10"); // write during wait
      cyc(1'b1, 8'h40, 1'b0, 2'd0, "R10");
      cyc(1'b1, 8'h40, 1'b0, 2'd0, "R10");
      cyc(1'b1, 8'h40, 1'b0, 2'd0, "R10");
      cyc(1'b0, 8'h40, 1'b0, 2'd0, "R10");
      access(8'h40, 3, "R10");          // now count 0

      for (int k = 0; k < 400; k++) begin
         int len = 1 + int'($urandom % 6);
         int gap = 1 + int'($urandom % 3);
         bit [PW-1:0] p = PW'($urandom % 4);
         for (int i = 0; i < len; i++) begin
            bit we = ($urandom % 9) == 0;
            cyc(1'b1, p, we, 2'($urandom), "random");
         end
         for (int i = 0; i < gap; i++) cyc(1'b0, p, 1'b0, 2'd0, "random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule